// File: doc/BRIEF.md
# Serial Hex-Text Memory Loader

This block sits behind a UART receiver and turns a stream of ASCII text into word writes to on-board SRAM. The host sends one record per text line: a hexadecimal byte address, a separator, then a hexadecimal data word. The block classifies each received character, shifts hex digits into a 32-bit address field and a 32-bit data field, and checks the record when the line ends. A well-formed record produces one write strobe carrying the word index and the data.

Anything after the second field on a line is dropped. A record whose address is all ones ends the download. The block then emits a single-cycle start pulse so that the processor can begin execution, and it ignores all further input until reset. Malformed characters, overlong fields and addresses that fall outside the 32 KB memory or are not word aligned raise a sticky error flag. The offending record is not written.

Top module: `hexload_top`

## Requirements
- R1: After reset `mem_we`, `start_pulse` and `err_flag` are all 0.
- R2: A line holding an address field and a data field, each 1 to 8 hex digits given most-significant digit first, separated by one or more spaces (0x20) or tabs (0x09) and ended by CR (0x0D) or LF (0x0A), raises `mem_we` for exactly one cycle. The pulse comes in the cycle after the terminator byte is accepted. It carries `mem_addr` = address bits [14:2] and `mem_wdata` = the data value.
- R3: Digits 0-9, A-F and a-f are accepted, and upper and lower case give the same value.
- R4: Leading separators and repeated separators are allowed. Every character after the second field up to the line end is ignored, including non-hex characters.
- R5: A line with fewer than two fields (an empty line, a CR LF pair, or an address alone) produces no write and no error.
- R6: An address of 0x8000 or above, or one whose bits [1:0] are not 00, raises `err_flag` in the cycle after the terminator and produces no write. Address 0x7FFC is written normally as word 0x1FFF.
- R7: Any character that is not a hex digit, separator or terminator, and that arrives before the second field is closed, raises `err_flag` in the cycle after it is accepted. No write is made for that line.
- R8: A ninth digit in either field raises `err_flag` and discards the line. Exactly eight digits are accepted.
- R9: A line whose address field is 0xFFFFFFFF raises `start_pulse` for exactly one cycle, in the cycle after its terminator, with or without a data field. It makes no write.
- R10: After the start pulse all input is ignored until reset: no writes, no further start pulse, and `err_flag` keeps its value.
- R11: `err_flag` stays 1 until reset, and later well-formed lines are still written.
- R12: Bytes presented while `rx_valid` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_data | input | 8 | Received ASCII byte |
| mem_addr | output | 13 | SRAM word index (byte address bits [14:2]) |
| mem_wdata | output | 32 | SRAM write data |
| mem_we | output | 1 | SRAM write strobe, one cycle per record |
| start_pulse | output | 1 | One-cycle pulse that starts program execution |
| err_flag | output | 1 | Sticky load error |

## Verification
There is one register between each accepted byte and every output. A write strobe or start pulse is due exactly one cycle after its terminator byte. An error is due one cycle after the offending character, or after the terminator for an address fault. The bench drives each byte for one cycle from the falling edge. A monitor samples the outputs on the following falling edge and counts write strobes and start pulses, so a pulse that is missing, duplicated or one cycle late changes the counts that the checks compare. The sweep writes 64 aligned addresses spread across the memory in four text formats. Error and termination cases each run from a fresh reset, so that the rise of the sticky flag can be attributed to a single line.

// File: rtl/hexload_pkg.sv
package hexload_pkg;

    // Character classes seen by the line parser.
    typedef enum logic [1:0] {
        CH_HEX = 2'd0,
        CH_SEP = 2'd1,
        CH_EOL = 2'd2,
        CH_BAD = 2'd3
    } chclass_e;

    localparam logic [7:0] ASC_SPACE = 8'h20;
    localparam logic [7:0] ASC_TAB   = 8'h09;
    localparam logic [7:0] ASC_CR    = 8'h0D;
    localparam logic [7:0] ASC_LF    = 8'h0A;

endpackage

// File: rtl/hexload_charclass.sv
module hexload_charclass
    import hexload_pkg::*;
(
    input  logic [7:0] ch,
    output chclass_e   cls,
    output logic [3:0] nib
);

    always_comb begin
        cls = CH_BAD;
        nib = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            cls = CH_HEX;
            nib = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            cls = CH_HEX;
            nib = 4'(ch - 8'h37);
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            cls = CH_HEX;
            nib = 4'(ch - 8'h57);
        end else if (ch == ASC_SPACE || ch == ASC_TAB) begin
            cls = CH_SEP;
        end else if (ch == ASC_CR || ch == ASC_LF) begin
            cls = CH_EOL;
        end
    end

endmodule

// File: rtl/hexload_field.sv
module hexload_field #(
    parameter int WIDTH = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              shift,
    input  logic [3:0]                        nib,
    output logic [WIDTH-1:0]                  val,
    output logic [$clog2(WIDTH/4+1)-1:0]      ndig,
    output logic                              full
);

    localparam int DIGITS = WIDTH / 4;
    localparam int CW     = $clog2(DIGITS + 1);

    typedef struct packed {
        logic [WIDTH-1:0] acc;
        logic [CW-1:0]    cnt;
    } fld_s;

    fld_s fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (clr) begin
            fld_d.acc = '0;
            fld_d.cnt = '0;
        end else if (shift) begin
            fld_d.acc = {fld_q.acc[WIDTH-5:0], nib};
            fld_d.cnt = fld_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign val  = fld_q.acc;
    assign ndig = fld_q.cnt;
    assign full = (fld_q.cnt == CW'(DIGITS));

endmodule

// File: rtl/hexload_top.sv
module hexload_top
    import hexload_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MEM_BYTES = 32768
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rx_valid,
    input  logic [7:0]                       rx_data,
    output logic [$clog2(MEM_BYTES)-3:0]     mem_addr,
    output logic [WORD_W-1:0]                mem_wdata,
    output logic                             mem_we,
    output logic                             start_pulse,
    output logic                             err_flag
);

    localparam int BYTE_AW = $clog2(MEM_BYTES);
    localparam int WORD_AW = BYTE_AW - 2;
    localparam int NFIELD  = 2;
    localparam int CW      = $clog2(WORD_W / 4 + 1);
    localparam logic [WORD_W-1:0] MEM_LIMIT = WORD_W'(MEM_BYTES);
    localparam logic [WORD_W-1:0] END_ADDR  = '1;

    typedef struct packed {
        logic [1:0]         fidx;
        logic               line_bad;
        logic               done;
        logic               err;
        logic               we;
        logic               start;
        logic [WORD_AW-1:0] waddr;
        logic [WORD_W-1:0]  wdata;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    chclass_e   cls;
    logic [3:0] nib;

    hexload_charclass u_cls (
        .ch  (rx_data),
        .cls (cls),
        .nib (nib)
    );

    logic [WORD_W-1:0] fval  [NFIELD];
    logic [CW-1:0]     fndig [NFIELD];
    logic [NFIELD-1:0] ffull;
    logic [NFIELD-1:0] fshift;
    logic              fclr;
    logic              hit;
    logic              active;

    assign hit    = rx_valid && !ctl_q.done;
    assign active = !ctl_q.line_bad && (ctl_q.fidx < 2'(NFIELD));
    assign fclr   = hit && (cls == CH_EOL);

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        assign fshift[g] = hit && active && (cls == CH_HEX) &&
                           (ctl_q.fidx == 2'(g)) && !ffull[g];

        hexload_field #(
            .WIDTH (WORD_W)
        ) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (fclr),
            .shift (fshift[g]),
            .nib   (nib),
            .val   (fval[g]),
            .ndig  (fndig[g]),
            .full  (ffull[g])
        );
    end

    logic cur_full;
    logic cur_has;
    logic got_addr;
    logic got_data;
    logic addr_fault;

    always_comb begin
        cur_full = 1'b0;
        cur_has  = 1'b0;
        for (int i = 0; i < NFIELD; i++) begin
            if (ctl_q.fidx == 2'(i)) begin
                cur_full = ffull[i];
                cur_has  = (fndig[i] != '0);
            end
        end
        got_addr   = (fndig[0] != '0);
        got_data   = (fndig[1] != '0);
        addr_fault = (fval[0] >= MEM_LIMIT) || (fval[0][1:0] != 2'b00);
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.we    = 1'b0;
        ctl_d.start = 1'b0;
        if (hit) begin
            unique case (cls)
                CH_HEX: begin
                    if (active && cur_full) begin
                        ctl_d.err      = 1'b1;
                        ctl_d.line_bad = 1'b1;
                    end
                end
                CH_SEP: begin
                    if (active && cur_has) begin
                        ctl_d.fidx = ctl_q.fidx + 2'd1;
                    end
                end
                CH_EOL: begin
                    ctl_d.fidx     = 2'd0;
                    ctl_d.line_bad = 1'b0;
                    if (!ctl_q.line_bad && got_addr) begin
                        if (fval[0] == END_ADDR) begin
                            ctl_d.done  = 1'b1;
                            ctl_d.start = 1'b1;
                        end else if (got_data) begin
                            if (addr_fault) begin
                                ctl_d.err = 1'b1;
                            end else begin
                                ctl_d.we    = 1'b1;
                                ctl_d.waddr = fval[0][BYTE_AW-1:2];
                                ctl_d.wdata = fval[1];
                            end
                        end
                    end
                end
                default: begin
                    if (active) begin
                        ctl_d.err      = 1'b1;
                        ctl_d.line_bad = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_addr    = ctl_q.waddr;
    assign mem_wdata   = ctl_q.wdata;
    assign mem_we      = ctl_q.we;
    assign start_pulse = ctl_q.start;
    assign err_flag    = ctl_q.err;

endmodule

// File: rtl/hexload_chk.sv
module hexload_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       mem_we,
    input logic       start_pulse,
    input logic       err_flag
);

    logic seen_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_start <= 1'b0;
        end else if (start_pulse) begin
            seen_start <= 1'b1;
        end
    end

    // R2: a write only follows an accepted line terminator
    a_r2_write_after_eol: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(rx_valid) && ($past(rx_data) == 8'h0A || $past(rx_data) == 8'h0D)));

    // R9: start lasts one cycle and never coincides with a write
    a_r9_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    a_r9_no_write_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !mem_we);

    // R10: silent after the start pulse
    a_r10_silent_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        seen_start |-> (!mem_we && !start_pulse));

    // R11: error flag is sticky
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R12: an idle input cycle causes no event
    a_r12_idle_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> (!mem_we && !start_pulse && $stable(err_flag)));

endmodule

bind hexload_top hexload_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .mem_we      (mem_we),
    .start_pulse (start_pulse),
    .err_flag    (err_flag)
);

// File: tb/hexload_top_tb.sv
`timescale 1ns/1ps
module hexload_top_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [12:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        start_pulse;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int st_cnt = 0;
    logic [12:0] last_a = '0;
    logic [31:0] last_d = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hexload_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_we      (mem_we),
        .start_pulse (start_pulse),
        .err_flag    (err_flag)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                wr_cnt = wr_cnt + 1;
                last_a = mem_addr;
                last_d = mem_wdata;
            end
            if (start_pulse) st_cnt = st_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rx_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
        #1;
    endtask

    task automatic expect_write(input string tag, input int w0, input logic [12:0] ea, input logic [31:0] ed);
        chk(wr_cnt == w0 + 1 && last_a == ea && last_d == ed, tag,
            {19'd0, last_a, last_d}, {19'd0, ea, ed});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w0;
        int s0;
        do_reset();
        // R1
        chk(!mem_we && !start_pulse && !err_flag, "R1 reset state",
            {mem_we, start_pulse, err_flag}, 0);

        // R2 / R3 sweep across memory in four text formats
        for (int k = 0; k < 64; k++) begin
            logic [31:0] a;
            logic [31:0] d;
            string s;
            a = 32'(k) * 32'h1FC;
            d = (32'(k) * 32'h9E3779B9) ^ 32'h0F0F0A0B;
            case (k % 4)
                0: s = $sformatf("%0h %0h\n", a, d);
                1: begin s = $sformatf("%0h\t%0h\r", a, d); s = s.toupper(); end
                2: s = $sformatf("%h %h\r\n", a, d);
                default: begin s = $sformatf("%h\t\t%0h  \n", a, d); s = s.toupper(); end
            endcase
            w0 = wr_cnt;
            send_str(s);
            expect_write((k % 2 == 1) ? "R3 upper-case line" : "R2 line write", w0, a[14:2], d);
        end
        chk(!err_flag, "R2 no error after sweep", err_flag, 0);

        // R12: idle bytes ignored
        w0 = wr_cnt;
        send_str("100 5");
        rx_data = 8'h0A;
        repeat (5) @(negedge clk);
        #1;
        chk(wr_cnt == w0, "R12 invalid byte ignored", wr_cnt - w0, 0);
        send_str("\n");
        expect_write("R12 write after valid terminator", w0, 13'h40, 32'h5);

        // R4: extra fields and separators
        w0 = wr_cnt;
        send_str("200 abc ff zz!#\n");
        expect_write("R4 extra fields ignored", w0, 13'h80, 32'habc);
        w0 = wr_cnt;
        send_str("  204\t \t7 \r");
        expect_write("R4 leading and repeated separators", w0, 13'h81, 32'h7);

        // R5: short lines
        w0 = wr_cnt;
        send_str("\n\r\n  \r300\n300 \n");
        chk(wr_cnt == w0 && !err_flag, "R5 short lines skipped", wr_cnt - w0, 0);

        // R8: exactly eight digits accepted
        w0 = wr_cnt;
        send_str("00000010 FFFFFFFF\n");
        expect_write("R8 eight digits accepted", w0, 13'h4, 32'hFFFFFFFF);

        // R6: boundary word
        w0 = wr_cnt;
        send_str("7ffc 1234\n");
        expect_write("R6 top word written", w0, 13'h1FFF, 32'h1234);
        chk(!err_flag, "R6 top word no error", err_flag, 0);

        // R6: out of range
        do_reset();
        w0 = wr_cnt;
        send_str("8000 1\n");
        chk(err_flag && wr_cnt == w0, "R6 range fault", {err_flag, 8'(wr_cnt - w0)}, 9'h100);
        // R11: sticky and later lines still written
        w0 = wr_cnt;
        send_str("10 22\n");
        expect_write("R11 write after error", w0, 13'h4, 32'h22);
        chk(err_flag, "R11 error sticky", err_flag, 1);

        // R6: misaligned
        do_reset();
        w0 = wr_cnt;
        send_str("102 1\n");
        chk(err_flag && wr_cnt == w0, "R6 alignment fault", {err_flag, 8'(wr_cnt - w0)}, 9'h100);

        // R7: bad character in data field
        do_reset();
        w0 = wr_cnt;
        send_str("10 g");
        chk(err_flag, "R7 error on bad char", err_flag, 1);
        send_str("5\n");
        chk(wr_cnt == w0, "R7 line discarded", wr_cnt - w0, 0);

        // R8: ninth digit
        do_reset();
        w0 = wr_cnt;
        send_str("000000010 1\n");
        chk(err_flag && wr_cnt == w0, "R8 ninth digit", {err_flag, 8'(wr_cnt - w0)}, 9'h100);

        // R9: terminator with address only
        do_reset();
        w0 = wr_cnt;
        s0 = st_cnt;
        send_str("ffffffff\n");
        chk(st_cnt == s0 + 1 && wr_cnt == w0, "R9 start pulse once",
            {8'(st_cnt - s0), 8'(wr_cnt - w0)}, 16'h0100);
        // R10: ignored afterwards
        send_str("100 1\nFFFFFFFF 0\nzz\n");
        chk(st_cnt == s0 + 1 && wr_cnt == w0 && !err_flag, "R10 input ignored after start",
            {8'(st_cnt - s0), 8'(wr_cnt - w0), 7'd0, err_flag}, 24'h010000);

        // R9: terminator with data field
        do_reset();
        w0 = wr_cnt;
        s0 = st_cnt;
        send_str("FFFFFFFF 1234\r");
        chk(st_cnt == s0 + 1 && wr_cnt == w0, "R9 start with data field",
            {8'(st_cnt - s0), 8'(wr_cnt - w0)}, 16'h0100);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule